// File: doc/BRIEF.md
# Dual-Bank Integration Sequencer

This block drives the switch network of a two-sided, ping-pong integrating front end that serves 16 current inputs. Every input has two integrators, side A and side B. An external conversion-control level chooses which side collects charge. The other side is digitized and then made ready for its next turn. The block follows that level through a two-flop synchronizer. On each change of the synchronized level it swaps the sides and starts a measurement sequence on the side that has just stopped integrating.

During a measurement, four converters are shared across the 16 channels. Each converter therefore samples four integrator outputs in turn, one slot after another, and each slot takes a fixed number of clock cycles. The side is discharged back to the reference only after its last slot. It then waits, idle, until the control level hands it the integrating role again. The measurement is 274 cycles long in fast mode and 544 cycles long in normal mode. When it ends, a one-cycle pulse announces that the result set is ready and names the measured side.

The block also times each integration period. A period shorter than the minimum for the current speed sets a sticky error flag, and the result set taken from that period is marked invalid.

Top module: `dual_bank_sequencer`

## Requirements
- R1: While reset is held, intSw is 2'b10 (side B integrating), convSw, rstSw, adcSel and dataReady are zero, and timingError is low.
- R2: Bit 0 of every two-bit side vector is side A and bit 1 is side B. Exactly one bit of intSw is high: side A when the synchronized convIn is 1, side B when it is 0. A change of convIn reaches intSw at the third rising clock edge after it is sampled.
- R3: The measurement starts on the same edge as the swap. For the first NUM_CONV*ADC_LAT cycles (4*50 by default) the measured side's convSw bit is high, and adcSel counts 0,1,2,3, holding each value for ADC_LAT cycles. adcSel is 0 whenever no conversion is running.
- R4: The measured side's rstSw bit is high only for the last RST_LEN cycles of the measurement, which come after all conversions. In the cycles between the conversions and the reset, and after the measurement, both convSw and rstSw are low.
- R5: The measurement length is fixed at the swap: MEAS_NORM (544) cycles when normalMode is 1, MEAS_FAST (274) when it is 0.
- R6: dataReady is high for exactly one cycle, measurement-length cycles after the swap. readySide then holds the measured side (0 = A, 1 = B).
- R7: An integration period shorter than MIN_NORM (800) cycles in normal mode, or MIN_FAST (400) in fast mode, sets timingError, which stays high until reset. The result set measured from that period reports readyValid = 0. Periods at least the minimum long give readyValid = 1. The first period is counted from the release of reset.
- R8: A swap that arrives before a measurement ends abandons that measurement with no dataReady pulse and starts a new one on the other side.
- R9: If a swap falls on the cycle in which dataReady would rise, the pulse is still issued with the finished set's side and validity, and the new measurement starts in that same cycle.
- R10: The integrating side never has its convSw or rstSw bit high, and no side has convSw and rstSw high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| convIn | input | 1 | Side-select level, asynchronous: 1 = A integrates, 0 = B |
| normalMode | input | 1 | 1 = normal timing, 0 = fast timing |
| intSw | output | 2 | Integrate switch enable per side |
| convSw | output | 2 | Converter connect enable per side |
| rstSw | output | 2 | Reference reset switch enable per side |
| adcSel | output | SEL_W (2) | Converter input slot during conversion |
| dataReady | output | 1 | One-cycle pulse: result set complete |
| readySide | output | 1 | Side of the last completed set (0 = A) |
| readyValid | output | 1 | Last completed set came from a long-enough period |
| timingError | output | 1 | Sticky short-integration flag |

## Verification
The interaction that needs the most care is a side swap landing in the same cycle as the end-of-measurement pulse. At that point the completion report of the old set and the start of the new set update the same registers at once. The bench provokes this by making the integration spacing equal to the measurement length, and it sweeps the spacing cycle by cycle through the whole measurement window in both speed modes. This covers aborted sets, the exact coincidence and normal completion. A cycle-counting model in the bench decides in each case whether the pulse must appear, which side it names, which validity it carries, and which side is converting in the same cycle.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  // Phase of the side that is not integrating
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CONVERT,
    PH_WAIT_RST,
    PH_RESET,
    PH_WAIT_INT
  } phase_e;

  // Strobes from control to datapath, valid in the cycle before a swap edge
  typedef struct packed {
    logic start;     // begin a measurement on the next edge
    logic side;      // side to measure: 0 = A, 1 = B
    logic valid;     // integration period was long enough
    logic longMeas;  // normal-mode measurement length
  } seqStrobe_t;

endpackage

// File: rtl/dbs_control.sv
module dbs_control
  import dbs_pkg::*;
#(
  parameter int MIN_FAST = 400,
  parameter int MIN_NORM = 800,
  parameter int MAX_INT  = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convIn,
  input  logic       normalMode,
  output seqStrobe_t strobe,
  output logic       intA,
  output logic       timingError
);

  localparam int CNT_W = $clog2(MAX_INT + 1);
  localparam logic [CNT_W:0] MIN_N_V = (CNT_W + 1)'(MIN_NORM);
  localparam logic [CNT_W:0] MIN_F_V = (CNT_W + 1)'(MIN_FAST);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(MAX_INT);

  logic convMeta, convSync, convPrev;
  logic [CNT_W-1:0] intCount;
  logic [CNT_W:0] elapsed, minLen;
  logic edgeSeen, tooShort;

  // two-flop synchronizer and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convMeta <= 1'b0;
      convSync <= 1'b0;
      convPrev <= 1'b0;
    end else begin
      convMeta <= convIn;
      convSync <= convMeta;
      convPrev <= convSync;
    end
  end

  assign edgeSeen = convSync ^ convPrev;
  assign elapsed  = {1'b0, intCount} + (CNT_W + 1)'(1);
  assign minLen   = normalMode ? MIN_N_V : MIN_F_V;
  assign tooShort = edgeSeen && (elapsed < minLen);

  // integration period timer, saturating at the longest legal period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCount    <= '0;
      timingError <= 1'b0;
    end else begin
      if (edgeSeen)              intCount <= '0;
      else if (intCount != SAT_V) intCount <= intCount + CNT_W'(1);
      if (tooShort) timingError <= 1'b1;
    end
  end

  always_comb begin
    strobe.start    = edgeSeen;
    strobe.side     = convSync;  // new level 1: A integrates, B is measured
    strobe.valid    = !tooShort;
    strobe.longMeas = normalMode;
  end

  assign intA = convPrev;

endmodule

// File: rtl/dbs_datapath.sv
module dbs_datapath
  import dbs_pkg::*;
#(
  parameter int MEAS_FAST = 274,
  parameter int MEAS_NORM = 544,
  parameter int ADC_LAT   = 50,
  parameter int NUM_CONV  = 4,
  parameter int RST_LEN   = 20,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  output logic [1:0]       convSw,
  output logic [1:0]       rstSw,
  output logic [SEL_W-1:0] adcSel,
  output logic             dataReady,
  output logic             readySide,
  output logic             readyValid
);

  localparam int MEAS_MAX = (MEAS_NORM > MEAS_FAST) ? MEAS_NORM : MEAS_FAST;
  localparam int MEAS_W   = $clog2(MEAS_MAX + 1);
  localparam int LAT_W    = (ADC_LAT > 1) ? $clog2(ADC_LAT) : 1;
  localparam logic [MEAS_W-1:0] LEN_N  = MEAS_W'(MEAS_NORM);
  localparam logic [MEAS_W-1:0] LEN_F  = MEAS_W'(MEAS_FAST);
  localparam logic [MEAS_W-1:0] RSTB_N = MEAS_W'(MEAS_NORM - RST_LEN);
  localparam logic [MEAS_W-1:0] RSTB_F = MEAS_W'(MEAS_FAST - RST_LEN);
  localparam logic [LAT_W-1:0]  LAT_END  = LAT_W'(ADC_LAT - 1);
  localparam logic [SEL_W-1:0]  SLOT_END = SEL_W'(NUM_CONV - 1);

  logic running, converting, measSide, measValid, lastCycle;
  logic [MEAS_W-1:0] measCnt, measLen, rstStart;
  logic [SEL_W-1:0]  slot;
  logic [LAT_W-1:0]  lat;
  phase_e phase;

  assign lastCycle = running && (measCnt == measLen - MEAS_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      converting <= 1'b0;
      measSide   <= 1'b0;
      measValid  <= 1'b0;
      measCnt    <= '0;
      measLen    <= LEN_F;
      rstStart   <= RSTB_F;
      slot       <= '0;
      lat        <= '0;
      dataReady  <= 1'b0;
      readySide  <= 1'b0;
      readyValid <= 1'b0;
    end else begin
      // completion report uses the finishing set even if a swap lands now
      dataReady <= lastCycle;
      if (lastCycle) begin
        readySide  <= measSide;
        readyValid <= measValid;
      end
      if (strobe.start) begin
        running    <= 1'b1;
        converting <= 1'b1;
        measSide   <= strobe.side;
        measValid  <= strobe.valid;
        measCnt    <= '0;
        measLen    <= strobe.longMeas ? LEN_N : LEN_F;
        rstStart   <= strobe.longMeas ? RSTB_N : RSTB_F;
        slot       <= '0;
        lat        <= '0;
      end else if (running) begin
        if (measCnt != measLen) measCnt <= measCnt + MEAS_W'(1);
        if (converting) begin
          if (lat == LAT_END) begin
            lat <= '0;
            if (slot == SLOT_END) converting <= 1'b0;
            else                  slot <= slot + SEL_W'(1);
          end else begin
            lat <= lat + LAT_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    if (!running)                phase = PH_IDLE;
    else if (converting)         phase = PH_CONVERT;
    else if (measCnt < rstStart) phase = PH_WAIT_RST;
    else if (measCnt < measLen)  phase = PH_RESET;
    else                         phase = PH_WAIT_INT;
  end

  assign adcSel = (phase == PH_CONVERT) ? slot : '0;

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign convSw[s] = (phase == PH_CONVERT) && (measSide == 1'(s));
    assign rstSw[s]  = (phase == PH_RESET)   && (measSide == 1'(s));
  end

endmodule

// File: rtl/dual_bank_sequencer.sv
module dual_bank_sequencer
  import dbs_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_ADC   = 4,
  parameter int MEAS_FAST = 274,
  parameter int MEAS_NORM = 544,
  parameter int MIN_FAST  = 400,
  parameter int MIN_NORM  = 800,
  parameter int MAX_FAST  = 1000,
  parameter int MAX_NORM  = 40000,
  parameter int ADC_LAT   = 50,
  parameter int RST_LEN   = 20,
  localparam int NUM_CONV = NUM_CH / NUM_ADC,
  localparam int SEL_W    = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convIn,
  input  logic             normalMode,
  output logic [1:0]       intSw,
  output logic [1:0]       convSw,
  output logic [1:0]       rstSw,
  output logic [SEL_W-1:0] adcSel,
  output logic             dataReady,
  output logic             readySide,
  output logic             readyValid,
  output logic             timingError
);

  localparam int MAX_INT = (MAX_NORM > MAX_FAST) ? MAX_NORM : MAX_FAST;

  seqStrobe_t strobe;
  logic intA;

  dbs_control #(
    .MIN_FAST(MIN_FAST),
    .MIN_NORM(MIN_NORM),
    .MAX_INT (MAX_INT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convIn     (convIn),
    .normalMode (normalMode),
    .strobe     (strobe),
    .intA       (intA),
    .timingError(timingError)
  );

  dbs_datapath #(
    .MEAS_FAST(MEAS_FAST),
    .MEAS_NORM(MEAS_NORM),
    .ADC_LAT  (ADC_LAT),
    .NUM_CONV (NUM_CONV),
    .RST_LEN  (RST_LEN),
    .SEL_W    (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .convSw    (convSw),
    .rstSw     (rstSw),
    .adcSel    (adcSel),
    .dataReady (dataReady),
    .readySide (readySide),
    .readyValid(readyValid)
  );

  assign intSw = {~intA, intA};

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       intSw,
  input logic [1:0]       convSw,
  input logic [1:0]       rstSw,
  input logic [SEL_W-1:0] adcSel,
  input logic             dataReady,
  input logic             timingError
);

  // R2
  int_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(intSw) == 1);

  // R10
  int_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((convSw | rstSw) & intSw) == 2'b00);

  // R10
  conv_rst_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convSw & rstSw) == 2'b00);

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingError |=> timingError);

  // R4
  rst_no_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstSw != 2'b00) |=> ((convSw & $past(rstSw)) == 2'b00));

  // R3
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convSw == 2'b00) |-> (adcSel == '0));

endmodule

bind dual_bank_sequencer dbs_checker #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_dual_bank_sequencer.sv
module tb_dual_bank_sequencer;

  localparam int MF  = 20;
  localparam int MN  = 30;
  localparam int MINF = 40;
  localparam int MINN = 60;
  localparam int LAT = 3;
  localparam int RST = 4;
  localparam int NCONV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convIn = 1'b0;
  logic normalMode = 1'b1;
  logic [1:0] intSw, convSw, rstSw;
  logic [1:0] adcSel;
  logic dataReady, readySide, readyValid, timingError;

  always #5 clk = ~clk;

  dual_bank_sequencer #(
    .NUM_CH(16), .NUM_ADC(4), .MEAS_FAST(MF), .MEAS_NORM(MN),
    .MIN_FAST(MINF), .MIN_NORM(MINN), .MAX_FAST(100), .MAX_NORM(400),
    .ADC_LAT(LAT), .RST_LEN(RST)
  ) dut (
    .clk(clk), .rstN(rstN), .convIn(convIn), .normalMode(normalMode),
    .intSw(intSw), .convSw(convSw), .rstSw(rstSw), .adcSel(adcSel),
    .dataReady(dataReady), .readySide(readySide), .readyValid(readyValid),
    .timingError(timingError)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  string focus = "reset";

  // bench model of the sequence
  int pend = -1;
  bit pendLevel, pendSpeed;
  int mEff, mLen, lastEff;
  bit mRun, mSide, mValid, mActA, mErr;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, focus, cyc, act, exp);
    end
  endtask

  task automatic step();
    int j, sideBits, expSel, expConvSw, expRstSw;
    bit expReady, expRS, expRV, coincide;
    @(negedge clk);
    cyc++;
    expReady = 1'b0; expRS = 1'b0; expRV = 1'b0; coincide = 1'b0;
    if (mRun && (cyc - mEff) == mLen) begin
      expReady = 1'b1; expRS = mSide; expRV = mValid;
    end
    if (pend == cyc) begin
      coincide = expReady;
      if ((cyc - lastEff) < (pendSpeed ? MINN : MINF)) begin
        mErr = 1'b1; mValid = 1'b0;
      end else begin
        mValid = 1'b1;
      end
      mLen = pendSpeed ? MN : MF;
      mSide = pendLevel;
      mActA = pendLevel;
      mEff = cyc;
      mRun = 1'b1;
      lastEff = cyc;
      pend = -1;
    end
    j = cyc - mEff;
    sideBits = mSide ? 2 : 1;
    expConvSw = (mRun && j < NCONV * LAT) ? sideBits : 0;
    expSel = (expConvSw != 0) ? j / LAT : 0;
    expRstSw = (mRun && j >= mLen - RST && j < mLen) ? sideBits : 0;
    chk("R2", int'(intSw), mActA ? 1 : 2);
    chk("R3", int'(convSw), expConvSw);
    chk("R3", int'(adcSel), expSel);
    chk("R4", int'(rstSw), expRstSw);
    // R5 length selection and R6 pulse timing; R9 when it coincides with a swap
    chk(coincide ? "R9" : "R5_R6", int'(dataReady), int'(expReady));
    if (expReady) begin
      chk("R6", int'(readySide), int'(expRS));
      chk("R7", int'(readyValid), int'(expRV));
    end
    chk("R7", int'(timingError), int'(mErr));
    chk("R10", int'((convSw | rstSw) & intSw), 0);
    chk("R10", int'(convSw & rstSw), 0);
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic period(int sp);
    convIn = ~convIn;
    pend = cyc + 3;
    pendLevel = convIn;
    pendSpeed = normalMode;
    repeat (sp) step();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    convIn = 1'b0;
    pend = -1;
    repeat (3) begin
      @(negedge clk);
      cyc++;
    end
    focus = "reset";
    chk("R1", int'(intSw), 2);
    chk("R1", int'(convSw), 0);
    chk("R1", int'(rstSw), 0);
    chk("R1", int'(adcSel), 0);
    chk("R1", int'(dataReady), 0);
    chk("R1", int'(timingError), 0);
    rstN = 1'b1;
    lastEff = cyc;
    mEff = cyc;
    mRun = 1'b0; mActA = 1'b0; mErr = 1'b0; mSide = 1'b0; mValid = 1'b0;
    mLen = MF;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog expired at cycle %0d: actual=hung expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R2 R3 R4 R5 R6: normal mode, regular periods
    normalMode = 1'b1;
    doReset();
    focus = "normal";
    idle(70);
    repeat (4) period(70);

    // R5: fast mode periods
    focus = "fast";
    normalMode = 1'b0;
    repeat (4) period(45);

    // R7: period length around the minimum in both modes
    focus = "R7 boundary";
    for (int md = 0; md < 2; md++) begin
      for (int sp = -3; sp <= 2; sp++) begin
        normalMode = md[0];
        doReset();
        focus = "R7 boundary";
        idle(70);
        period((md == 1 ? MINN : MINF) + sp);
        period(80);
        period(80);
      end
    end

    // R8 R9: swap spacing swept across the whole measurement window
    for (int md = 0; md < 2; md++) begin
      for (int sp = 4; sp <= (md == 1 ? MN : MF) + 6; sp++) begin
        normalMode = md[0];
        doReset();
        focus = "R8 R9 sweep";
        idle(70);
        period(70);
        period(sp);
        period(70);
        period(70);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule